// File: doc/BRIEF.md
# PCI Bus Address Window Translator

This block converts the addresses of inbound PCI bus transactions into system memory addresses. Software programs a set of address windows. Each window has three registers: a match base, a size mask and a translated base. The first enabled window whose high address bits match the incoming address decides how the address is turned into a system address. An address that hits no window leaves the block unchanged, zero-extended to the system width.

A window works in one of two modes.

- **Direct mode:** the bus address offset inside the window is placed onto the translated base.
- **Scatter-gather mode:** the block builds the address of a 64-bit page-table entry, fetches that entry over a simple memory request/reply port, and combines the entry's page frame with the low 13 bits of the bus address.

Translation requests and results travel over valid/ready handshakes. Only one translation is in flight at a time. A 64-bit control register sits in the same register space and is plain storage.

Top module: `pci_win_xlate`

## Requirements
- R1: After reset every window register reads zero. The control register reads 64'h0000_0021_0010_0000 (bit 20 set, bit 32 set, value 2 in bits 39:36). `req_ready` is high and `rsp_valid` and `mem_req_valid` are low.
- R2: The register map on `reg_addr` is as follows: window i match base at i, size mask at NUM_WIN+i, translated base at 2*NUM_WIN+i, control at 3*NUM_WIN. `reg_rdata` shows the addressed register in the same cycle. The control register keeps all 64 written bits. Base and mask keep bits 31:0 and the translated base keeps bits SYS_W-1:0; higher bits read as zero.
- R3: Window i hits when match-base bit 0 (enable) is set and the address equals the match base on every bit of 31:20 where the size mask is zero. Mask bits that are set remove those address bits from the compare.
- R4: Windows are searched from index 0 upward and the lowest-index hit wins. A window whose enable bit is clear is skipped and the search goes on.
- R5: A hit window with match-base bit 1 clear maps directly. The offset mask M is (size mask & 32'hFFF0_0000) | 32'h000F_FFFF. The result is (translated base & ~M) | (bus address & M).
- R6: A hit window with match-base bit 1 set issues one table read. The table-entry address is (translated base & ~(((size mask & 32'hFFF0_0000) >> 10) | 32'h3FF)) | ((bus address & ((size mask & 32'hFFF0_0000) | 32'h000F_E000)) >> 10). This address is always 8-byte aligned. `mem_req_valid` and `mem_req_addr` hold until `mem_req_ready` is seen.
- R7: The scatter-gather result is ((entry & ~1) << 12) | bus address[12:0], truncated to SYS_W bits.
- R8: An address that hits no window returns the bus address unchanged, zero-extended.
- R9: For direct or unmatched addresses, `rsp_valid` rises in the cycle after the request is accepted. For scatter-gather, it rises in the cycle after `mem_rsp_valid`. `req_ready` stays low from acceptance until the result is taken.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_addr` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register index for write and read |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Read data of the indexed register |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | PCI bus address to translate |
| rsp_valid | output | 1 | Translated address valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_addr | output | SYS_W | Translated system address |
| mem_req_valid | output | 1 | Page-table entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | SYS_W | Address of the 64-bit table entry |
| mem_rsp_valid | input | 1 | Table entry returned |
| mem_rsp_data | input | 64 | Table entry contents |

## Verification
The bench makes two windows overlap. It checks that the lower index wins, and that clearing that window's enable hands the address to the next window. A design with a reversed search, or one that stops at a disabled match, would return the other window's base.

Addresses are placed so that the window hit depends on size-mask bits inside 31:20. One address sits just outside a window. A compare that used the mask uninverted would hit or miss the wrong addresses, and that outside address would translate instead of passing through.

Scatter-gather requests are stalled on both the request and the reply side, with a page-table entry whose bit 0 is set. A design that dropped the request early, mixed the shift amounts, or kept entry bit 0 would show a wrong table address or a wrong bit 12 in the result.

// File: rtl/pwt_pkg.sv
package pwt_pkg;

   localparam int BUS_W  = 32;
   localparam int PTE_W  = 64;
   localparam int CTRL_W = 64;
   localparam int PAGE_LOW_W = 13;

   // high address field used for window compare
   localparam logic [BUS_W-1:0] HI_FIELD   = 32'hFFF0_0000;
   // offset bits always inside a direct window
   localparam logic [BUS_W-1:0] OFS_FILL   = 32'h000F_FFFF;
   // page index bits below the window field for table lookup
   localparam logic [BUS_W-1:0] PIDX_FILL  = 32'h000F_E000;
   // low bits always cleared from the table base
   localparam logic [BUS_W-1:0] TBL_FILL   = 32'h0000_03FF;
   localparam int TBL_SHIFT = 10;

   localparam logic [CTRL_W-1:0] CTRL_RST =
      (64'h1 << 20) | (64'h1 << 32) | (64'h2 << 36);

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_MREQ  = 2'd1,
      SEQ_MWAIT = 2'd2,
      SEQ_RESP  = 2'd3
   } seq_state_t;

endpackage

// File: rtl/pwt_regs.sv
module pwt_regs
   import pwt_pkg::*;
#(
   parameter int NUM_WIN = 4,
   parameter int SYS_W   = 40,
   parameter int REG_AW  = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [REG_AW-1:0]             addr,
   input  logic [63:0]                   wdata,
   output logic [63:0]                   rdata,
   output logic [NUM_WIN-1:0][BUS_W-1:0] base_q,
   output logic [NUM_WIN-1:0][BUS_W-1:0] mask_q,
   output logic [NUM_WIN-1:0][SYS_W-1:0] tbase_q
);

   localparam int MASK_OFS  = NUM_WIN;
   localparam int TBASE_OFS = 2 * NUM_WIN;
   localparam int CTRL_IDX  = 3 * NUM_WIN;

   logic [CTRL_W-1:0] ctrl_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         ctrl_q <= CTRL_RST;
      else if (wr_en && addr == REG_AW'(CTRL_IDX))
         ctrl_q <= wdata;
   end

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            base_q[w]  <= '0;
            mask_q[w]  <= '0;
            tbase_q[w] <= '0;
         end else if (wr_en) begin
            if (addr == REG_AW'(w))
               base_q[w] <= wdata[BUS_W-1:0];
            if (addr == REG_AW'(MASK_OFS + w))
               mask_q[w] <= wdata[BUS_W-1:0];
            if (addr == REG_AW'(TBASE_OFS + w))
               tbase_q[w] <= wdata[SYS_W-1:0];
         end
      end
   end

   logic wdata_unused;
   assign wdata_unused = ^wdata;

   always_comb begin
      rdata = '0;
      if (addr == REG_AW'(CTRL_IDX))
         rdata = ctrl_q;
      for (int k = 0; k < NUM_WIN; k++) begin
         if (addr == REG_AW'(k))
            rdata = {{(64-BUS_W){1'b0}}, base_q[k]};
         if (addr == REG_AW'(MASK_OFS + k))
            rdata = {{(64-BUS_W){1'b0}}, mask_q[k]};
         if (addr == REG_AW'(TBASE_OFS + k))
            rdata = {{(64-SYS_W){1'b0}}, tbase_q[k]};
      end
   end

endmodule

// File: rtl/pwt_window.sv
module pwt_window
   import pwt_pkg::*;
#(
   parameter int SYS_W = 40
) (
   input  logic [BUS_W-1:0] bus_addr,
   input  logic [BUS_W-1:0] win_base,
   input  logic [BUS_W-1:0] win_mask,
   input  logic [SYS_W-1:0] win_tbase,
   output logic             hit,
   output logic             sg_mode,
   output logic [SYS_W-1:0] direct_addr,
   output logic [SYS_W-1:0] table_addr
);

   localparam int PAD = SYS_W - BUS_W;

   logic [BUS_W-1:0] size_hi;
   logic [BUS_W-1:0] cmp_sel;
   logic [BUS_W-1:0] ofs_sel;
   logic [BUS_W-1:0] pidx_sel;
   logic [BUS_W-1:0] tbl_clr;

   always_comb begin
      size_hi  = win_mask & HI_FIELD;
      cmp_sel  = ~win_mask & HI_FIELD;
      ofs_sel  = size_hi | OFS_FILL;
      pidx_sel = size_hi | PIDX_FILL;
      tbl_clr  = (size_hi >> TBL_SHIFT) | TBL_FILL;

      hit      = win_base[0] && ((bus_addr & cmp_sel) == (win_base & cmp_sel));
      sg_mode  = win_base[1];

      direct_addr = (win_tbase & ~{{PAD{1'b0}}, ofs_sel})
                  | {{PAD{1'b0}}, bus_addr & ofs_sel};
      table_addr  = (win_tbase & ~{{PAD{1'b0}}, tbl_clr})
                  | {{PAD{1'b0}}, (bus_addr & pidx_sel) >> TBL_SHIFT};
   end

endmodule

// File: rtl/pwt_select.sv
module pwt_select
   import pwt_pkg::*;
#(
   parameter int NUM_WIN = 4,
   parameter int SYS_W   = 40
) (
   input  logic [BUS_W-1:0]              bus_addr,
   input  logic [NUM_WIN-1:0]            hit,
   input  logic [NUM_WIN-1:0]            sg_mode,
   input  logic [NUM_WIN-1:0][SYS_W-1:0] direct_addr,
   input  logic [NUM_WIN-1:0][SYS_W-1:0] table_addr,
   output logic                          use_sg,
   output logic [SYS_W-1:0]              plain_result,
   output logic [SYS_W-1:0]              sel_table
);

   // scan from the top down so the lowest index is written last and wins
   always_comb begin
      use_sg       = 1'b0;
      plain_result = {{(SYS_W-BUS_W){1'b0}}, bus_addr};
      sel_table    = '0;
      for (int k = NUM_WIN - 1; k >= 0; k--) begin
         if (hit[k]) begin
            use_sg       = sg_mode[k];
            plain_result = direct_addr[k];
            sel_table    = table_addr[k];
         end
      end
   end

endmodule

// File: rtl/pwt_seq.sv
module pwt_seq
   import pwt_pkg::*;
#(
   parameter int SYS_W = 40
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic [PAGE_LOW_W-1:0] bus_low,
   input  logic                  use_sg,
   input  logic [SYS_W-1:0]      plain_result,
   input  logic [SYS_W-1:0]      sel_table,
   output logic                  mem_req_valid,
   input  logic                  mem_req_ready,
   output logic [SYS_W-1:0]      mem_req_addr,
   input  logic                  mem_rsp_valid,
   input  logic [PTE_W-1:0]      mem_rsp_data,
   output logic                  rsp_valid,
   input  logic                  rsp_ready,
   output logic [SYS_W-1:0]      rsp_addr
);

   localparam int FRAME_W = SYS_W - PAGE_LOW_W;

   seq_state_t            st_q;
   logic [SYS_W-1:0]      res_q;
   logic [SYS_W-1:0]      tbl_q;
   logic [PAGE_LOW_W-1:0] low_q;
   logic [SYS_W-1:0]      sg_result;
   logic                  pte_unused;

   // entry bit 0 is dropped, entry bit k lands at bit k+12; bit 12 comes from the bus
   assign sg_result  = {mem_rsp_data[FRAME_W:1], low_q};
   assign pte_unused = ^mem_rsp_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= SEQ_IDLE;
         res_q <= '0;
         tbl_q <= '0;
         low_q <= '0;
      end else begin
         unique case (st_q)
            SEQ_IDLE: if (req_valid) begin
               if (use_sg) begin
                  tbl_q <= sel_table;
                  low_q <= bus_low;
                  st_q  <= SEQ_MREQ;
               end else begin
                  res_q <= plain_result;
                  st_q  <= SEQ_RESP;
               end
            end
            SEQ_MREQ:  if (mem_req_ready) st_q <= SEQ_MWAIT;
            SEQ_MWAIT: if (mem_rsp_valid) begin
               res_q <= sg_result;
               st_q  <= SEQ_RESP;
            end
            SEQ_RESP:  if (rsp_ready) st_q <= SEQ_IDLE;
            default:   st_q <= SEQ_IDLE;
         endcase
      end
   end

   assign req_ready     = (st_q == SEQ_IDLE);
   assign mem_req_valid = (st_q == SEQ_MREQ);
   assign mem_req_addr  = tbl_q;
   assign rsp_valid     = (st_q == SEQ_RESP);
   assign rsp_addr      = res_q;

endmodule

// File: rtl/pci_win_xlate.sv
module pci_win_xlate
   import pwt_pkg::*;
#(
   parameter  int NUM_WIN = 4,
   parameter  int SYS_W   = 40,
   localparam int REG_AW  = $clog2(3 * NUM_WIN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [63:0]       reg_wdata,
   output logic [63:0]       reg_rdata,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [31:0]       req_addr,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [SYS_W-1:0]  rsp_addr,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [SYS_W-1:0]  mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [63:0]       mem_rsp_data
);

   if (NUM_WIN < 1 || NUM_WIN > 16) begin : g_bad_num_win
      $error("pci_win_xlate: NUM_WIN must be 1..16");
   end
   if (SYS_W <= BUS_W || SYS_W > 64) begin : g_bad_sys_w
      $error("pci_win_xlate: SYS_W must be 33..64");
   end

   logic [NUM_WIN-1:0][BUS_W-1:0] base_q;
   logic [NUM_WIN-1:0][BUS_W-1:0] mask_q;
   logic [NUM_WIN-1:0][SYS_W-1:0] tbase_q;
   logic [NUM_WIN-1:0]            win_hit;
   logic [NUM_WIN-1:0]            win_sg;
   logic [NUM_WIN-1:0][SYS_W-1:0] win_direct;
   logic [NUM_WIN-1:0][SYS_W-1:0] win_table;
   logic                          use_sg;
   logic [SYS_W-1:0]              plain_result;
   logic [SYS_W-1:0]              sel_table;

   pwt_regs #(.NUM_WIN(NUM_WIN), .SYS_W(SYS_W), .REG_AW(REG_AW)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr_en),
      .addr    (reg_addr),
      .wdata   (reg_wdata),
      .rdata   (reg_rdata),
      .base_q  (base_q),
      .mask_q  (mask_q),
      .tbase_q (tbase_q)
   );

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_window
      pwt_window #(.SYS_W(SYS_W)) u_win (
         .bus_addr    (req_addr),
         .win_base    (base_q[w]),
         .win_mask    (mask_q[w]),
         .win_tbase   (tbase_q[w]),
         .hit         (win_hit[w]),
         .sg_mode     (win_sg[w]),
         .direct_addr (win_direct[w]),
         .table_addr  (win_table[w])
      );
   end

   pwt_select #(.NUM_WIN(NUM_WIN), .SYS_W(SYS_W)) u_sel (
      .bus_addr     (req_addr),
      .hit          (win_hit),
      .sg_mode      (win_sg),
      .direct_addr  (win_direct),
      .table_addr   (win_table),
      .use_sg       (use_sg),
      .plain_result (plain_result),
      .sel_table    (sel_table)
   );

   pwt_seq #(.SYS_W(SYS_W)) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_ready     (req_ready),
      .bus_low       (req_addr[PAGE_LOW_W-1:0]),
      .use_sg        (use_sg),
      .plain_result  (plain_result),
      .sel_table     (sel_table),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_req_addr  (mem_req_addr),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data  (mem_rsp_data),
      .rsp_valid     (rsp_valid),
      .rsp_ready     (rsp_ready),
      .rsp_addr      (rsp_addr)
   );

endmodule

// File: rtl/pwt_checker.sv
module pwt_checker #(
   parameter int SYS_W = 40
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic             rsp_valid,
   input logic             rsp_ready,
   input logic [SYS_W-1:0] rsp_addr,
   input logic             mem_req_valid,
   input logic             mem_req_ready,
   input logic [SYS_W-1:0] mem_req_addr,
   input logic             mem_rsp_valid
);

   AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr))); // R10

   AST_MREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R6

   AST_MREQ_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> (mem_req_addr[2:0] == 3'b000)); // R6

   AST_SINGLE_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid || mem_req_valid) |-> !req_ready); // R9

   AST_RSP_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rsp_valid) |-> ($past(req_valid && req_ready) || $past(mem_rsp_valid))); // R9

endmodule

bind pci_win_xlate pwt_checker #(.SYS_W(SYS_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .rsp_valid     (rsp_valid),
   .rsp_ready     (rsp_ready),
   .rsp_addr      (rsp_addr),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_req_addr  (mem_req_addr),
   .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/sim_pci_win_xlate.sv
`timescale 1ns/1ps
module sim_pci_win_xlate;

   localparam int NW = 4;
   localparam int SW = 40;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr_en = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [63:0]   reg_wdata = '0;
   logic [63:0]   reg_rdata;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [31:0]   req_addr = '0;
   logic          rsp_valid;
   logic          rsp_ready = 1'b0;
   logic [SW-1:0] rsp_addr;
   logic          mem_req_valid;
   logic          mem_req_ready = 1'b0;
   logic [SW-1:0] mem_req_addr;
   logic          mem_rsp_valid = 1'b0;
   logic [63:0]   mem_rsp_data = '0;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   logic [31:0]   sb [NW];
   logic [31:0]   sm [NW];
   logic [SW-1:0] stb[NW];

   always #4 clk = ~clk;

   pci_win_xlate #(.NUM_WIN(NW), .SYS_W(SW)) u0 (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input int idx, input logic [63:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_addr = AW'(idx); reg_wdata = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic rd_chk(input int idx, input logic [63:0] exp, input string req);
      @(negedge clk);
      reg_addr = AW'(idx);
      #1;
      chk(reg_rdata == exp, req, reg_rdata, exp);
   endtask

   task automatic prog(input int w, input logic [31:0] b, input logic [31:0] m, input logic [SW-1:0] t);
      wr_reg(w, {32'h0, b});
      wr_reg(NW + w, {32'h0, m});
      wr_reg(2 * NW + w, {24'h0, t});
      sb[w] = b; sm[w] = m; stb[w] = t;
   endtask

   // reference model taken from the requirement formulas
   function automatic int find_win(input logic [31:0] a);
      for (int i = 0; i < NW; i++) begin
         logic [31:0] cm;
         cm = ~sm[i] & 32'hFFF0_0000;
         if (sb[i][0] && ((a & cm) == (sb[i] & cm))) return i;
      end
      return -1;
   endfunction

   function automatic logic [63:0] pte_of(input logic [SW-1:0] ta);
      return {24'h0, ta} ^ 64'h0000_0001_3C3C_3C3D;
   endfunction

   task automatic translate(input logic [31:0] a, input int rdy_dly, input int rsp_dly,
                            input int hold, input string req);
      int w;
      bit sg;
      logic [63:0] exp_t;
      logic [63:0] exp_r;
      logic [31:0] hi;
      logic [31:0] om;
      logic [31:0] tm;
      w = find_win(a);
      sg = (w >= 0) && sb[w][1];
      exp_t = '0;
      if (w < 0) begin
         exp_r = {32'h0, a};
      end else begin
         hi = sm[w] & 32'hFFF0_0000;
         om = hi | 32'h000F_FFFF;
         tm = (hi >> 10) | 32'h3FF;
         exp_r = ({24'h0, stb[w]} & ~{32'h0, om}) | {32'h0, a & om};
         exp_t = ({24'h0, stb[w]} & ~{32'h0, tm}) | {32'h0, (a & (hi | 32'h000F_E000)) >> 10};
         if (sg) exp_r = (((pte_of(exp_t[SW-1:0]) & ~64'h1) << 12) | {51'h0, a[12:0]}) & 64'h00FF_FFFF_FFFF;
      end
      @(negedge clk);
      chk(req_ready == 1'b1, "R9 idle ready", {63'h0, req_ready}, 64'h1);
      req_valid = 1'b1; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
      if (!sg) begin
         chk(rsp_valid == 1'b1, "R9 one-cycle result", {63'h0, rsp_valid}, 64'h1);
         chk(rsp_addr == exp_r[SW-1:0], req, {24'h0, rsp_addr}, exp_r);
      end else begin
         chk(mem_req_valid && !rsp_valid, "R6 table read issued", {63'h0, mem_req_valid}, 64'h1);
         chk(mem_req_addr == exp_t[SW-1:0], "R6 table address", {24'h0, mem_req_addr}, exp_t);
         for (int k = 0; k < rdy_dly; k++) begin
            @(negedge clk);
            chk(mem_req_valid && mem_req_addr == exp_t[SW-1:0], "R6 request held",
                {24'h0, mem_req_addr}, exp_t);
         end
         mem_req_ready = 1'b1;
         @(negedge clk);
         mem_req_ready = 1'b0;
         chk(!mem_req_valid, "R6 request dropped after accept", {63'h0, mem_req_valid}, 64'h0);
         for (int k = 0; k < rsp_dly; k++) begin
            @(negedge clk);
            chk(!rsp_valid && !req_ready, "R9 waiting for reply", {63'h0, rsp_valid}, 64'h0);
         end
         mem_rsp_valid = 1'b1; mem_rsp_data = pte_of(exp_t[SW-1:0]);
         @(negedge clk);
         mem_rsp_valid = 1'b0; mem_rsp_data = '0;
         chk(rsp_valid == 1'b1, "R9 result after reply", {63'h0, rsp_valid}, 64'h1);
         chk(rsp_addr == exp_r[SW-1:0], "R7 scatter-gather result", {24'h0, rsp_addr}, exp_r);
      end
      for (int k = 0; k < hold; k++) begin
         @(negedge clk);
         chk(rsp_valid && !req_ready && rsp_addr == exp_r[SW-1:0], "R10 result held",
             {24'h0, rsp_addr}, exp_r);
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      chk(!rsp_valid && req_ready, "R9 back to idle", {62'h0, rsp_valid, req_ready}, 64'h1);
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk(req_ready && !rsp_valid && !mem_req_valid, "R1 handshake reset",
          {61'h0, req_ready, rsp_valid, mem_req_valid}, 64'h4);
      for (int i = 0; i < 3 * NW; i++) rd_chk(i, 64'h0, "R1 window reg zero");
      rd_chk(3 * NW, 64'h0000_0021_0010_0000, "R1 control reset");
   endtask

   task automatic t_regs;
      wr_reg(3 * NW, 64'hA5A5_0000_FFFF_1234);
      rd_chk(3 * NW, 64'hA5A5_0000_FFFF_1234, "R2 control readback");
      wr_reg(2, 64'hFFFF_FFFF_1234_5678);
      rd_chk(2, 64'h0000_0000_1234_5678, "R2 base width");
      wr_reg(NW + 1, 64'hFFFF_0000_0FF0_0000);
      rd_chk(NW + 1, 64'h0000_0000_0FF0_0000, "R2 mask width");
      wr_reg(2 * NW + 3, 64'hFFFF_FFAB_CDEF_0123);
      rd_chk(2 * NW + 3, 64'h0000_00AB_CDEF_0123, "R2 tbase width");
      for (int i = 0; i < NW; i++) prog(i, 32'h0, 32'h0, '0);
   endtask

   task automatic t_passthrough;
      translate(32'hDEAD_BEEF, 0, 0, 0, "R8 no window enabled");
      prog(2, 32'hDEA0_0000, 32'h0, 40'hFF_0000_0000);
      translate(32'hDEAD_BEEF, 0, 0, 0, "R8 disabled window ignored");
   endtask

   task automatic t_direct;
      prog(1, 32'h4000_0001, 32'h0FF0_0000, 40'h12_3000_0000);
      translate(32'h4ABC_DEF0, 0, 0, 0, "R5 direct map");
      translate(32'h4FFF_FFFF, 0, 0, 0, "R3 masked bits ignored");
      translate(32'h5000_0000, 0, 0, 0, "R3 outside window passes");
   endtask

   task automatic t_priority;
      prog(0, 32'h4000_0001, 32'h3FF0_0000, 40'h77_0000_0000);
      translate(32'h4ABC_DEF0, 0, 0, 0, "R4 lowest index wins");
      prog(0, 32'h4000_0000, 32'h3FF0_0000, 40'h77_0000_0000);
      translate(32'h4ABC_DEF0, 0, 0, 0, "R4 disabled skipped");
   endtask

   task automatic t_sg;
      prog(3, 32'h8000_0003, 32'h0030_0000, 40'h55_0000_0000);
      translate(32'h8023_4567, 3, 2, 0, "R7 sg");
      translate(32'h803F_FFFF, 0, 0, 0, "R7 sg");
      prog(2, 32'hC000_0003, 32'h0000_0000, 40'h66_0000_1000);
      translate(32'hC00A_1234, 1, 0, 0, "R7 sg");
   endtask

   task automatic t_backpressure;
      translate(32'h4123_4567, 0, 0, 4, "R5 direct under stall");
      translate(32'h8011_2233, 0, 1, 3, "R7 sg under stall");
   endtask

   task automatic finish_run;
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      for (int i = 0; i < NW; i++) begin sb[i] = '0; sm[i] = '0; stb[i] = '0; end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regs();
      t_passthrough();
      t_direct();
      t_priority();
      t_sg();
      t_backpressure();
      repeat (2) @(negedge clk);
      finish_run();
   end

   initial begin
      #(8 * 50000);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

endmodule